// File: doc/BRIEF.md
# Packed Single-Precision Compare Unit

This unit compares two 128-bit operands that each carry four IEEE-754 single-precision values. Lane k of the first operand is compared only with lane k of the second. The first operand is always the left-hand side of the relation. An 8-bit predicate code picks one of eight relations. Each 32-bit lane of the result is filled with ones when the relation holds and with zeros when it does not. The all-zeros pattern reads as +0.0 and the all-ones pattern reads as a quiet NaN, so a later arithmetic operation can consume the mask without faulting.

The unit takes a request on a valid/ready input and returns the mask one clock later in a register, together with a flag for undefined predicate codes. It is always ready. The unit offers no greater-than forms. A caller gets them by swapping the operands and using less-than or less-or-equal.

Top module: `fcmp_packed_unit`

## Requirements
- R1: The operands split into lanes at bits 31:0, 63:32, 95:64 and 127:96. Each result lane depends only on the same lane of `opnd_a` (left side) and `opnd_b` (right side).
- R2: Every 32-bit lane of `out_mask` is either 0xFFFFFFFF (the relation holds) or 0x00000000 (it fails).
- R3: The codes 0 to 7 of `pred_code` select these relations, in order: equal, less-than, less-or-equal, unordered, not-equal, not-less-than, not-less-or-equal, ordered.
- R4: Any `pred_code` from 8 to 255 sets `out_rsvd` to 1 and forces the whole `out_mask` to zero. For codes 0 to 7, `out_rsvd` is 0.
- R5: A value is NaN when its exponent field (bits 30:23) is all ones and its fraction field (bits 22:0) is non-zero. If either side of a lane is NaN, equal, less-than, less-or-equal and ordered are false, and unordered, not-equal, not-less-than and not-less-or-equal are true.
- R6: +0.0 and -0.0 compare equal, and neither is less than the other.
- R7: Non-NaN values follow numeric order. Any negative value is below any positive value. Of two negatives, the one with the larger magnitude is smaller. The infinities lie beyond every finite value.
- R8: `in_ready` is 1 whenever the unit is out of reset. `out_valid` is 1 in exactly the cycle after an accepted request. `out_mask` and `out_rsvd` change only on the clock edge that accepts a request.
- R9: While `rst_n` is low, `out_mask` is zero and `out_valid` and `out_rsvd` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| opnd_a | input | 128 | Left-hand operands, four lanes |
| opnd_b | input | 128 | Right-hand operands, four lanes |
| pred_code | input | 8 | Predicate selector |
| out_valid | output | 1 | Result registered this cycle |
| out_mask | output | 128 | Per-lane all-ones/all-zeros result |
| out_rsvd | output | 1 | Predicate code was undefined |

## Verification
Assertions check on every cycle the rules that can be stated without knowing the operand values:
- Each result lane is all ones or all zeros.
- An undefined code yields a zero mask.
- `out_valid` follows acceptance by exactly one cycle, and the result holds while idle.
- Inside each lane, an unordered pair is never reported as equal or less-than.
- Equal and less-than never hold together.

Only the bench's scenarios can show the numeric content of the result, because that content depends on the operand values. This covers:
- which predicate each code selects;
- the treatment of signed zeros;
- the order of negatives and of infinities;
- the independence of the four lanes.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  // Relation codes; the numeric order is the external selector encoding.
  typedef enum logic [2:0] {
    PRED_EQ    = 3'd0,
    PRED_LT    = 3'd1,
    PRED_LE    = 3'd2,
    PRED_UNORD = 3'd3,
    PRED_NEQ   = 3'd4,
    PRED_NLT   = 3'd5,
    PRED_NLE   = 3'd6,
    PRED_ORD   = 3'd7
  } pred_e;

  // Basic relation of a lane pair from which every predicate is derived.
  typedef struct packed {
    logic unord;
    logic eq;
    logic lt;
  } rel_t;

endpackage

// File: rtl/fcmp_pred_dec.sv
module fcmp_pred_dec
  import fcmp_pkg::*;
#(
  parameter int IMM_W = 8
) (
  input  logic [IMM_W-1:0] code,
  output pred_e            pred,
  output logic             rsvd
);

  localparam int SEL_W = $bits(pred_e);

  // Any set bit above the selector field marks a reserved code.
  assign rsvd = |code[IMM_W-1:SEL_W];
  assign pred = pred_e'(code[SEL_W-1:0]);

endmodule

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] val,
  output logic                 is_nan,
  output logic                 is_zero
);

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;

  assign exp_f   = val[EXP_W+MAN_W-1:MAN_W];
  assign man_f   = val[MAN_W-1:0];
  assign is_nan  = (&exp_f) && (|man_f);
  assign is_zero = ~|val[EXP_W+MAN_W-1:0];

endmodule

// File: rtl/fcmp_lane.sv
module fcmp_lane
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [EXP_W+MAN_W:0] lhs,
  input  logic [EXP_W+MAN_W:0] rhs,
  input  pred_e                pred,
  output logic                 hit
);

  localparam int LW    = EXP_W + MAN_W + 1;
  localparam int MAG_W = LW - 1;

  logic             l_nan, l_zero, r_nan, r_zero;
  logic [MAG_W-1:0] l_mag, r_mag;
  logic             l_sgn, r_sgn;
  logic             both_zero;
  rel_t             rel;

  fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_l (
    .val(lhs), .is_nan(l_nan), .is_zero(l_zero)
  );
  fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_r (
    .val(rhs), .is_nan(r_nan), .is_zero(r_zero)
  );

  assign l_mag     = lhs[MAG_W-1:0];
  assign r_mag     = rhs[MAG_W-1:0];
  assign l_sgn     = lhs[LW-1];
  assign r_sgn     = rhs[LW-1];
  assign both_zero = l_zero && r_zero;

  // Relation: sign first, then magnitude, inverted for two negatives.
  always_comb begin
    rel.unord = l_nan || r_nan;
    rel.eq    = 1'b0;
    rel.lt    = 1'b0;
    if (!rel.unord) begin
      if (both_zero) begin
        rel.eq = 1'b1;
      end else if (l_sgn != r_sgn) begin
        rel.lt = l_sgn;
      end else if (l_mag == r_mag) begin
        rel.eq = 1'b1;
      end else begin
        rel.lt = l_sgn ? (l_mag > r_mag) : (l_mag < r_mag);
      end
    end
  end

  always_comb begin
    unique case (pred)
      PRED_EQ:    hit = rel.eq;
      PRED_LT:    hit = rel.lt;
      PRED_LE:    hit = rel.lt || rel.eq;
      PRED_UNORD: hit = rel.unord;
      PRED_NEQ:   hit = !rel.eq;
      PRED_NLT:   hit = !rel.lt;
      PRED_NLE:   hit = !(rel.lt || rel.eq);
      PRED_ORD:   hit = !rel.unord;
      default:    hit = 1'b0;
    endcase
  end

  // R5
  nan_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_nan || r_nan) |-> !(rel.eq || rel.lt));

  // R7
  eq_lt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rel.eq && rel.lt));

endmodule

// File: rtl/fcmp_packed_unit.sv
module fcmp_packed_unit
  import fcmp_pkg::*;
#(
  parameter int LANES = 4,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int IMM_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [LANES*(EXP_W+MAN_W+1)-1:0] opnd_a,
  input  logic [LANES*(EXP_W+MAN_W+1)-1:0] opnd_b,
  input  logic [IMM_W-1:0]             pred_code,
  output logic                         out_valid,
  output logic [LANES*(EXP_W+MAN_W+1)-1:0] out_mask,
  output logic                         out_rsvd
);

  localparam int LW = EXP_W + MAN_W + 1;
  localparam int DW = LANES * LW;

  pred_e           pred;
  logic            rsvd;
  logic            accept;
  logic [DW-1:0]   lane_mask;
  logic [DW-1:0]   mask_d, mask_q;
  logic            rsvd_d, rsvd_q;
  logic            valid_d, valid_q;

  assign in_ready = 1'b1;
  assign accept   = in_valid && in_ready;

  fcmp_pred_dec #(.IMM_W(IMM_W)) u_dec (
    .code(pred_code), .pred(pred), .rsvd(rsvd)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit;
    fcmp_lane #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_lane (
      .clk (clk),
      .rst_n(rst_n),
      .lhs (opnd_a[g*LW +: LW]),
      .rhs (opnd_b[g*LW +: LW]),
      .pred(pred),
      .hit (hit)
    );
    assign lane_mask[g*LW +: LW] = {LW{hit}};

    // R2
    lane_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_mask[g*LW +: LW] == '0) || (out_mask[g*LW +: LW] == '1));
  end

  // Next-state logic
  always_comb begin
    mask_d  = mask_q;
    rsvd_d  = rsvd_q;
    valid_d = accept;
    if (accept) begin
      mask_d = rsvd ? '0 : lane_mask;
      rsvd_d = rsvd;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      rsvd_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      mask_q  <= mask_d;
      rsvd_q  <= rsvd_d;
      valid_q <= valid_d;
    end
  end

  assign out_mask  = mask_q;
  assign out_rsvd  = rsvd_q;
  assign out_valid = valid_q;

  // R4
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_rsvd |-> (out_mask == '0));

  // R8
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R8
  valid_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_mask) && $stable(out_rsvd)));

endmodule

// File: tb/tb_fcmp_packed_unit.sv
module tb_fcmp_packed_unit;

  localparam int CLK_PERIOD = 10;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [127:0] opnd_a, opnd_b;
  logic [7:0]   pred_code;
  logic         out_valid;
  logic [127:0] out_mask;
  logic         out_rsvd;

  int n_run  = 0;
  int n_fail = 0;

  logic         exp_valid;
  logic [127:0] exp_mask;
  logic         exp_rsvd;

  fcmp_packed_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .pred_code(pred_code),
    .out_valid(out_valid), .out_mask(out_mask), .out_rsvd(out_rsvd)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Sample values
  localparam logic [31:0] P1   = 32'h3F800000, P2 = 32'h40000000;
  localparam logic [31:0] N1   = 32'hBF800000, N2 = 32'hC0000000;
  localparam logic [31:0] PZ   = 32'h00000000, NZ = 32'h80000000;
  localparam logic [31:0] PINF = 32'h7F800000, NINF = 32'hFF800000;
  localparam logic [31:0] QNAN = 32'h7FC00000, SNAN = 32'h7F800001;
  localparam logic [31:0] PMAX = 32'h7F7FFFFF, NMAX = 32'hFF7FFFFF;

  // Behavioural reference: ordered values mapped to signed integer keys.
  function automatic logic ref_hit(logic [31:0] a, logic [31:0] b, int p);
    logic   un;
    longint ka, kb;
    logic   eq, lt;
    un = ((a[30:23] == 8'hFF) && (a[22:0] != 0)) ||
         ((b[30:23] == 8'hFF) && (b[22:0] != 0));
    ka = a[31] ? -longint'(a[30:0]) : longint'(a[30:0]);
    kb = b[31] ? -longint'(b[30:0]) : longint'(b[30:0]);
    eq = !un && (ka == kb);
    lt = !un && (ka < kb);
    case (p)
      0: return eq;
      1: return lt;
      2: return lt || eq;
      3: return un;
      4: return !eq;
      5: return !lt;
      6: return !(lt || eq);
      default: return !un;
    endcase
  endfunction

  function automatic logic [127:0] ref_mask(logic [127:0] a, logic [127:0] b, int code);
    logic [127:0] m;
    m = '0;
    if (code < 8)
      for (int k = 0; k < 4; k++)
        m[k*32 +: 32] = ref_hit(a[k*32 +: 32], b[k*32 +: 32], code) ? 32'hFFFFFFFF : 32'h0;
    return m;
  endfunction

  task automatic compare(string tag);
    n_run++;
    if (out_valid !== exp_valid || out_mask !== exp_mask ||
        out_rsvd !== exp_rsvd || in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL %s: valid=%0b mask=%032h rsvd=%0b ready=%0b expected valid=%0b mask=%032h rsvd=%0b ready=1",
               tag, out_valid, out_mask, out_rsvd, in_ready, exp_valid, exp_mask, exp_rsvd);
    end
  endtask

  // Drive at a falling edge, model the next rising edge, check at the next falling edge.
  task automatic step(logic v, logic [127:0] a, logic [127:0] b, logic [7:0] code, string tag);
    in_valid  = v;
    opnd_a    = a;
    opnd_b    = b;
    pred_code = code;
    exp_valid = v;
    if (v) begin
      exp_rsvd = (code >= 8);
      exp_mask = ref_mask(a, b, int'(code));
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic lanes(logic [31:0] a0, logic [31:0] b0, logic [31:0] a1, logic [31:0] b1,
                       logic [31:0] a2, logic [31:0] b2, logic [31:0] a3, logic [31:0] b3,
                       int code, string tag);
    step(1'b1, {a3, a2, a1, a0}, {b3, b2, b1, b0}, 8'(code), tag);
  endtask

  task automatic do_reset(string tag);
    rst_n = 1'b0;
    in_valid = 1'b0;
    exp_valid = 1'b0; exp_mask = '0; exp_rsvd = 1'b0;
    repeat (2) @(negedge clk);
    compare(tag);
    rst_n = 1'b1;
    @(negedge clk);
    compare(tag);
  endtask

  function automatic logic [31:0] pick(int i);
    case (i % 12)
      0: return P1;   1: return P2;   2: return N1;   3: return N2;
      4: return PZ;   5: return NZ;   6: return PINF; 7: return NINF;
      8: return QNAN; 9: return SNAN; 10: return PMAX; default: return NMAX;
    endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    in_valid = 1'b0; opnd_a = '0; opnd_b = '0; pred_code = '0;
    exp_valid = 1'b0; exp_mask = '0; exp_rsvd = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    do_reset("R9");

    // R3: every code on a mixed set of lanes
    for (int c = 0; c < 8; c++)
      lanes(P1, P2, P2, P1, N1, N1, QNAN, P1, c, "R3");

    // R1: each lane different, results per lane position
    lanes(P1, P2, P2, P1, P1, P1, N2, N1, 1, "R1");
    lanes(P2, P1, P1, P1, P1, P2, N1, N2, 1, "R1");

    // R2: all lanes true and all false
    lanes(P1, P1, N1, N1, PZ, PZ, PINF, PINF, 0, "R2");
    lanes(P1, P2, N1, N2, PZ, P1, PINF, NINF, 0, "R2");

    // R5: NaN on each side, every code
    for (int c = 0; c < 8; c++)
      lanes(QNAN, P1, P1, SNAN, QNAN, QNAN, SNAN, NINF, c, "R5");

    // R6: signed zeros
    lanes(PZ, NZ, NZ, PZ, NZ, NZ, PZ, PZ, 0, "R6");
    lanes(PZ, NZ, NZ, PZ, NZ, NZ, PZ, PZ, 1, "R6");
    lanes(PZ, NZ, NZ, PZ, NZ, P1, N1, NZ, 2, "R6");

    // R7: negatives, infinities, extremes
    lanes(N2, N1, N1, N2, NINF, NMAX, PMAX, PINF, 1, "R7");
    lanes(N1, P1, P1, N1, NINF, PINF, NMAX, PZ, 1, "R7");
    lanes(N2, N1, N1, N2, NINF, NMAX, PMAX, PINF, 6, "R7");

    // R4: reserved codes, including boundaries
    lanes(P1, P1, P1, P1, P1, P1, P1, P1, 8, "R4");
    lanes(P1, P1, P1, P1, P1, P1, P1, P1, 255, "R4");
    lanes(QNAN, P1, P1, P2, N1, N1, PZ, NZ, 4, "R4");
    lanes(P1, P2, P1, P2, P1, P2, P1, P2, 129, "R4");

    // R8: idle cycles hold the result; back-to-back requests
    step(1'b1, {P1, P1, P1, P1}, {P2, P2, P2, P2}, 8'd1, "R8");
    step(1'b0, {N1, N1, N1, N1}, {P1, P1, P1, P1}, 8'd4, "R8");
    step(1'b0, '0, '0, 8'd200, "R8");
    step(1'b1, {P2, P2, P2, P2}, {P1, P1, P1, P1}, 8'd1, "R8");
    step(1'b1, {P2, P2, P2, P2}, {P1, P1, P1, P1}, 8'd5, "R8");
    step(1'b0, '0, '0, 8'd0, "R8");

    // R1: random mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [127:0] a, b;
      for (int k = 0; k < 4; k++) begin
        a[k*32 +: 32] = ($urandom % 3 == 0) ? $urandom : pick($urandom % 12);
        b[k*32 +: 32] = ($urandom % 4 == 0) ? a[k*32 +: 32] : pick($urandom % 12);
      end
      step(($urandom % 4) != 0, a, b, ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 8), "R1");
    end

    // R9: reset mid-run after a non-zero result
    lanes(P1, P1, P1, P1, P1, P1, P1, P1, 0, "R9");
    do_reset("R9");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule